// File: doc/BRIEF.md
# Video Memory Wait-State Generator

This block stalls CPU accesses that land in video memory on a system where the video dot clock runs at three times the CPU clock. The video side only hands the bus to the CPU at fixed points in its 16-dot character period. The stall therefore depends on where the access falls relative to that period. The block tracks that relationship from reset and holds ready low for the matching number of CPU clocks.

The block counts CPU clocks from reset and keeps, alongside that count, the dot position at which each CPU clock starts. When a video access is strobed, the stall length is worked out from three steps:

1. Let 8 dots pass.
2. Move to the next 16-dot character boundary that lies strictly beyond that point.
3. Round up to the start of the next CPU clock.

Accesses outside the video region are not stalled. The length of the most recent video stall is kept on a debug output.

Top module: `vid_wait_gen`

## Requirements
- R1: After reset, `ready` is 1 and `wait_cnt` is 0.
- R2: The access phase is the number of rising clock edges taken since reset was released, modulo 16. The first edge after release is phase 0. The phase advances on every edge, including edges inside a stall.
- R3: For an access at phase p, the CPU clock starts at dot 3p. The stall ends at dot B, where B is the first multiple of 16 strictly above 3p+8, rounded up to a multiple of 3. The stall length is (B-3p)/3 clocks. For example, phase 0 gives 6, phase 3 gives 8, phase 8 gives 8 and phase 13 gives 3.
- R4: A video access is accepted on an edge where `acc_stb`=1, `vid_sel`=1 and `ready`=1. From that edge, `ready` stays 0 for exactly the stall length in clocks, then returns to 1.
- R5: From the accepting edge onward, `wait_cnt` shows that access's stall length. It keeps that value until the next accepted video access.
- R6: A strobe with `vid_sel`=0 gets no stall: `ready` stays 1 and `wait_cnt` is unchanged.
- R7: A video strobe seen while `ready` is 0 is ignored. The current stall is neither lengthened nor restarted, and `wait_cnt` keeps its value.
- R8: Across the 16 phases, the stall lengths are the multiset {3, 4×3, 5×3, 6×3, 7×3, 8×3}.
- R9: A video strobe on the first edge at which `ready` is back at 1 is accepted at once. It starts a new stall with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_stb | input | 1 | CPU bus access strobe, one clock per access |
| vid_sel | input | 1 | Access address decodes to video memory |
| ready | output | 1 | CPU ready; driven to 0 while the video stall lasts |
| wait_cnt | output | 7 | Stall length of the last accepted video access |

## Verification
The hardest situations to reach are the rare phases: phase 13, the only phase that yields 3, and phase 8, which sits exactly on a character boundary after the lead-in. Reaching a given phase means controlling how many clocks have passed since reset, and each stall shifts that count by a different amount. The bench therefore tracks the edge count itself. For a directed sweep of all 16 phases, it idles until the count hits the wanted phase before each strobe. Random idle gaps, back-to-back strobes and strobes during a stall then reach each phase from many different histories.

// File: rtl/vid_wait_gen.sv
module vid_wait_gen #(
  parameter int CPU_DOTS  = 3,
  parameter int CHAR_DOTS = 16,
  parameter int LEAD_DOTS = 8,
  localparam int DW = $clog2(CHAR_DOTS),
  localparam int CW = $clog2(2 * CHAR_DOTS + LEAD_DOTS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_stb,
  input  logic          vid_sel,
  output logic          ready,
  output logic [CW-1:0] wait_cnt
);

  logic [DW:0]   dot_ph;
  logic [CW-1:0] remain;

  wire [DW:0] dsum  = dot_ph + (DW+1)'(CPU_DOTS);
  wire [DW:0] dnext = (dsum >= (DW+1)'(CHAR_DOTS)) ? dsum - (DW+1)'(CHAR_DOTS) : dsum;

  wire [CW-1:0] lead = CW'(dot_ph) + CW'(LEAD_DOTS);
  wire [CW-1:0] bnd  = (lead / CW'(CHAR_DOTS) + CW'(1)) * CW'(CHAR_DOTS);
  wire [CW-1:0] span = bnd - CW'(dot_ph);
  wire [CW-1:0] need = (span + CW'(CPU_DOTS - 1)) / CW'(CPU_DOTS);

  assign ready = (remain == '0);
  wire take = acc_stb & vid_sel & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_ph   <= '0;
      remain   <= '0;
      wait_cnt <= '0;
    end else begin
      dot_ph <= dnext;
      if (take) begin
        remain   <= need;
        wait_cnt <= need;
      end else if (!ready) begin
        remain <= remain - CW'(1);
      end
    end
  end

endmodule

// File: rtl/vid_wait_gen_chk.sv
module vid_wait_gen_chk #(
  parameter int CW     = 7,
  parameter int MIN_W  = 3,
  parameter int MAX_W  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_stb,
  input logic          vid_sel,
  input logic          ready,
  input logic [CW-1:0] wait_cnt
);

  logic [CW-1:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_cnt <= '0;
    else if (!ready) lo_cnt <= lo_cnt + CW'(1);
    else             lo_cnt <= '0;
  end

  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && vid_sel && ready) |=> !ready);

  p_stall_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && lo_cnt != '0) |-> (lo_cnt == wait_cnt));

  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (wait_cnt >= CW'(MIN_W) && wait_cnt <= CW'(MAX_W)));

  p_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !(acc_stb && vid_sel)) |=> (ready && $stable(wait_cnt)));

  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(wait_cnt));

endmodule

bind vid_wait_gen vid_wait_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .vid_sel(vid_sel),
  .ready(ready), .wait_cnt(wait_cnt)
);

// File: tb/vid_wait_gen_bench.sv
`timescale 1ns/1ps
module vid_wait_gen_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       acc_stb = 0;
  logic       vid_sel = 0;
  logic       ready;
  logic [6:0] wait_cnt;

  int checks = 0;
  int errors = 0;
  int edges = 0;
  int prev_w = 0;
  int hist [0:15];
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  vid_wait_gen u_vid_wait_gen (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .vid_sel(vid_sel),
    .ready(ready), .wait_cnt(wait_cnt)
  );

  function automatic int exp_wait(int p);
    int s = 3 * p;
    int t = s + 8;
    t++;
    while (t % 16 != 0) t++;
    while (t % 3 != 0) t++;
    return (t - s) / 3;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_phase(int p);
    while (edges % 16 != p) @(negedge clk);
  endtask

  task automatic run_access(bit vid, bit poke, string tag);
    int p = edges % 16;
    int e = exp_wait(p);
    int n = 0;
    acc_stb = 1; vid_sel = vid;
    @(negedge clk);
    acc_stb = 0; vid_sel = 0;
    if (!vid) begin
      check({tag, " R6 ready"}, ready, 1);
      check({tag, " R6 wait_cnt"}, wait_cnt, prev_w);
      return;
    end
    check({tag, " R4 ready low"}, ready, 0);
    check({tag, " R3/R5 wait_cnt"}, wait_cnt, e);
    while (!ready && n < 40) begin
      n++;
      if (poke && n == 1) begin acc_stb = 1; vid_sel = 1; end
      else begin acc_stb = 0; vid_sel = 0; end
      @(negedge clk);
    end
    acc_stb = 0; vid_sel = 0;
    check(poke ? {tag, " R7 stall len"} : {tag, " R4 stall len"}, n, e);
    check(poke ? {tag, " R7 wait_cnt"} : {tag, " R5 wait_cnt held"}, wait_cnt, e);
    prev_w = e;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 ready", ready, 1);
    check("R1 wait_cnt", wait_cnt, 0);
    rst_n = 1;

    // R2 R3 R8: directed sweep over every phase
    for (int p = 0; p < 16; p++) begin
      wait_phase(p);
      hist[exp_wait(p)]++;
      check("R3 model phase", edges % 16, p);
      run_access(1, 0, "R8 sweep");
    end
    check("R8 count of 3", hist[3], 1);
    for (int v = 4; v <= 8; v++) check("R8 count", hist[v], 3);

    // R3 corner phases 8 and 13
    wait_phase(8);  run_access(1, 0, "R3 phase8");
    wait_phase(13); run_access(1, 0, "R3 phase13");

    // R6 non-video
    wait_phase(5); run_access(0, 0, "R6 direct");

    // R7 strobe during stall
    wait_phase(3); run_access(1, 1, "R7 direct");

    // R9 back-to-back
    run_access(1, 0, "R9 first");
    run_access(1, 0, "R9 second");

    // R2 random mix
    for (int k = 0; k < 300; k++) begin
      int gap = $urandom_range(0, 21);
      repeat (gap) @(negedge clk);
      run_access($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, "R2 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule